// File: doc/BRIEF.md
# ModR/M Effective Address Decoder

This block takes the addressing byte that follows a 16-bit-mode opcode, together with the direction and width bits of that opcode, up to two displacement bytes and the current values of the four address registers (BX, BP, SI, DI). From these it works out whether the second operand is a register or a memory location. For register forms it reports which register. For memory forms it reports the 16-bit effective offset, the segment that the access uses, and how many displacement bytes follow the addressing byte.

Each request is accepted on a cycle where `in_valid` is high. One clock later the block presents the registered result, flagged by `out_valid`. A segment override input, when valid, replaces the segment that the addressing form would otherwise pick. Fetch logic uses the displacement-length output to advance past the displacement bytes. The execute stage uses the two operand selectors to route data in the right direction.

Top module: `modrm_ea_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `out_valid` low, `out_ea` zero and `out_disp_len` zero.
- R2: A mode field (bits 7:6) of 11 gives a register form: `out_is_mem` low, `out_disp_len` 0, `out_ea` 0, and the r/m field (bits 2:0) used as a register number.
- R3: Operand selectors are 4 bits wide. The value 4'b1000 means the memory operand, and {1'b0, n} means register n. The reg field is bits 5:3. With `dir_bit` 1 the destination is the reg-field register and the source is the r/m operand. With `dir_bit` 0 the two are swapped.
- R4: `out_wide` repeats `wide_bit` from the accepted request (0 byte, 1 word).
- R5: `out_disp_len` is 0 for mode 00, 1 for mode 01, 2 for mode 10 and 0 for mode 11. The one exception is mode 00 with r/m 110, which gives 2.
- R6: A one-byte displacement (`disp_lo`) is sign-extended: 00h-7Fh adds 0000h-007Fh, and 80h-FFh adds FF80h-FFFFh. A two-byte displacement is {`disp_hi`, `disp_lo`}.
- R7: In memory forms, r/m codes 0 to 7 address BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX, plus the displacement.
- R8: Mode 00 with r/m 110 is a direct address. The offset is the 16-bit displacement alone, and no register is added.
- R9: The offset sum is taken modulo 2^16, so any carry out of bit 15 is lost.
- R10: Segment codes are ES=0, CS=1, SS=2, DS=3. Memory forms that add BP default to SS, and all other memory forms default to DS. Register forms report DS.
- R11: When `ovr_valid` is high, a memory form reports `ovr_seg` as its segment. In register forms the override is ignored.
- R12: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. After a cycle without a request, all result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| dir_bit | input | 1 | Opcode direction bit |
| wide_bit | input | 1 | Opcode width bit |
| modrm | input | 8 | Addressing byte |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| bx_val | input | AW | Current BX value |
| bp_val | input | AW | Current BP value |
| si_val | input | AW | Current SI value |
| di_val | input | AW | Current DI value |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_wide | output | 1 | Operand width of the result |
| out_is_mem | output | 1 | Second operand is memory |
| out_dst_sel | output | 4 | Destination operand selector |
| out_src_sel | output | 4 | Source operand selector |
| out_ea | output | AW | Effective offset |
| out_seg | output | 2 | Segment code |
| out_disp_len | output | 2 | Displacement bytes consumed |

## Verification
The hardest cases to reach combine a form rule with a numeric edge. One is a BP-based form that reaches BP only through mode 01 with a zero displacement, because mode 00 with r/m 110 is taken over by direct addressing. The other is a negative one-byte displacement whose sum carries out of bit 15. The stimulus sets register values on purpose for these cases. It uses BP nonzero during the direct-address request, so that a wrongly added register shows up in the offset. It pairs BX=0100h with displacement 80h, and BX=1000h with DI=FF00h, so that the sign extension and the dropped carry each give a distinct expected offset. It also sweeps all eight r/m codes with distinct register values so that each base/index pairing can be told apart.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;

  localparam logic [2:0] RM_DIRECT   = 3'b110;
  localparam logic [3:0] SEL_MEMORY  = 4'b1000;

  typedef struct packed {
    logic       is_mem;
    logic       use_base;
    logic       base_is_bp;
    logic       use_index;
    logic       index_is_di;
    logic       stack_default;
    logic [1:0] disp_len;
  } ea_plan_t;

endpackage

// File: rtl/modrm_field_split.sv
module modrm_field_split
  import modrm_pkg::*;
(
  input  logic [7:0] modrm_i,
  output ea_plan_t   plan_o,
  output logic [2:0] reg_o,
  output logic [2:0] rm_o
);

  logic [1:0] mode_f;
  logic       direct;

  assign mode_f = modrm_i[7:6];
  assign reg_o  = modrm_i[5:3];
  assign rm_o   = modrm_i[2:0];
  assign direct = (mode_f == MODE_NODISP) && (rm_o == RM_DIRECT);

  always_comb begin
    plan_o = '0;
    plan_o.is_mem = (mode_f != MODE_REG);
    if (plan_o.is_mem) begin
      if (!rm_o[2]) begin
        plan_o.use_base    = 1'b1;
        plan_o.base_is_bp  = rm_o[1];
        plan_o.use_index   = 1'b1;
        plan_o.index_is_di = rm_o[0];
      end else begin
        unique case (rm_o[1:0])
          2'b00: plan_o.use_index = 1'b1;
          2'b01: begin
            plan_o.use_index   = 1'b1;
            plan_o.index_is_di = 1'b1;
          end
          2'b10: begin
            plan_o.use_base   = !direct;
            plan_o.base_is_bp = !direct;
          end
          default: plan_o.use_base = 1'b1;
        endcase
      end
    end
    plan_o.stack_default = plan_o.use_base && plan_o.base_is_bp;
    unique case (mode_f)
      MODE_NODISP: plan_o.disp_len = direct ? 2'd2 : 2'd0;
      MODE_DISP8:  plan_o.disp_len = 2'd1;
      MODE_DISP16: plan_o.disp_len = 2'd2;
      default:     plan_o.disp_len = 2'd0;
    endcase
  end

endmodule

// File: rtl/modrm_disp_ext.sv
module modrm_disp_ext #(
  parameter int AW = 16
) (
  input  logic [1:0]    disp_len_i,
  input  logic [7:0]    lo_i,
  input  logic [7:0]    hi_i,
  output logic [AW-1:0] disp_o
);

  logic signed [7:0] lo_s;
  logic [15:0]       word_v;

  assign lo_s   = $signed(lo_i);
  assign word_v = {hi_i, lo_i};

  always_comb begin
    unique case (disp_len_i)
      2'd1:    disp_o = AW'(lo_s);
      2'd2:    disp_o = AW'(word_v);
      default: disp_o = '0;
    endcase
  end

endmodule

// File: rtl/modrm_ea_adder.sv
module modrm_ea_adder #(
  parameter int AW      = 16,
  parameter bit USE_CSA = 1'b1
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] sum_o
);

  generate
    if (USE_CSA) begin : g_csa
      logic [AW-1:0] part_sum;
      logic [AW-1:0] carry_sh;
      assign carry_sh[0] = 1'b0;
      for (genvar i = 0; i < AW; i++) begin : g_bit
        assign part_sum[i] = base_i[i] ^ index_i[i] ^ disp_i[i];
        if (i < AW - 1) begin : g_cy
          assign carry_sh[i+1] = (base_i[i] & index_i[i]) |
                                 (base_i[i] & disp_i[i])  |
                                 (index_i[i] & disp_i[i]);
        end
      end
      assign sum_o = part_sum + carry_sh;
    end else begin : g_plain
      assign sum_o = base_i + index_i + disp_i;
    end
  endgenerate

endmodule

// File: rtl/modrm_ea_decoder.sv
module modrm_ea_decoder
  import modrm_pkg::*;
#(
  parameter int AW      = 16,
  parameter bit USE_CSA = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          dir_bit,
  input  logic          wide_bit,
  input  logic [7:0]    modrm,
  input  logic [7:0]    disp_lo,
  input  logic [7:0]    disp_hi,
  input  logic [AW-1:0] bx_val,
  input  logic [AW-1:0] bp_val,
  input  logic [AW-1:0] si_val,
  input  logic [AW-1:0] di_val,
  input  logic          ovr_valid,
  input  logic [1:0]    ovr_seg,
  output logic          out_valid,
  output logic          out_wide,
  output logic          out_is_mem,
  output logic [3:0]    out_dst_sel,
  output logic [3:0]    out_src_sel,
  output logic [AW-1:0] out_ea,
  output logic [1:0]    out_seg,
  output logic [1:0]    out_disp_len
);

  ea_plan_t      plan;
  logic [2:0]    reg_f;
  logic [2:0]    rm_f;
  logic [AW-1:0] disp_v;
  logic [AW-1:0] base_v;
  logic [AW-1:0] index_v;
  logic [AW-1:0] sum_v;
  logic [3:0]    reg_side;
  logic [3:0]    rm_side;
  seg_e          seg_n;

  modrm_field_split u_split (
    .modrm_i (modrm),
    .plan_o  (plan),
    .reg_o   (reg_f),
    .rm_o    (rm_f)
  );

  modrm_disp_ext #(.AW(AW)) u_disp (
    .disp_len_i (plan.disp_len),
    .lo_i       (disp_lo),
    .hi_i       (disp_hi),
    .disp_o     (disp_v)
  );

  assign base_v  = plan.use_base  ? (plan.base_is_bp  ? bp_val : bx_val) : '0;
  assign index_v = plan.use_index ? (plan.index_is_di ? di_val : si_val) : '0;

  modrm_ea_adder #(.AW(AW), .USE_CSA(USE_CSA)) u_add (
    .base_i  (base_v),
    .index_i (index_v),
    .disp_i  (disp_v),
    .sum_o   (sum_v)
  );

  assign reg_side = {1'b0, reg_f};
  assign rm_side  = plan.is_mem ? SEL_MEMORY : {1'b0, rm_f};

  always_comb begin
    if (!plan.is_mem)       seg_n = SEG_DS;
    else if (ovr_valid)     seg_n = seg_e'(ovr_seg);
    else if (plan.stack_default) seg_n = SEG_SS;
    else                    seg_n = SEG_DS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_wide     <= 1'b0;
      out_is_mem   <= 1'b0;
      out_dst_sel  <= '0;
      out_src_sel  <= '0;
      out_ea       <= '0;
      out_seg      <= SEG_DS;
      out_disp_len <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_wide     <= wide_bit;
        out_is_mem   <= plan.is_mem;
        out_dst_sel  <= dir_bit ? reg_side : rm_side;
        out_src_sel  <= dir_bit ? rm_side : reg_side;
        out_ea       <= plan.is_mem ? sum_v : '0;
        out_seg      <= seg_n;
        out_disp_len <= plan.disp_len;
      end
    end
  end

endmodule

// File: rtl/modrm_ea_checker.sv
module modrm_ea_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          dir_bit,
  input logic          wide_bit,
  input logic [7:0]    modrm,
  input logic [7:0]    disp_lo,
  input logic [7:0]    disp_hi,
  input logic [AW-1:0] bx_val,
  input logic [AW-1:0] bp_val,
  input logic [AW-1:0] si_val,
  input logic [AW-1:0] di_val,
  input logic          ovr_valid,
  input logic [1:0]    ovr_seg,
  input logic          out_valid,
  input logic          out_wide,
  input logic          out_is_mem,
  input logic [3:0]    out_dst_sel,
  input logic [3:0]    out_src_sel,
  input logic [AW-1:0] out_ea,
  input logic [1:0]    out_seg,
  input logic [1:0]    out_disp_len
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_ea == '0 && out_disp_len == 2'd0));

  p_regform_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_mem) |-> (out_disp_len == 2'd0 && out_ea == '0 && out_seg == 2'd3));

  p_one_mem_side_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_mem) |-> ($countones({out_dst_sel[3], out_src_sel[3]}) == 1));

  p_width_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_wide == $past(wide_bit)));

  p_disp8_len_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm[7:6] == 2'b01) |=> (out_disp_len == 2'd1));

  p_override_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ovr_valid && modrm[7:6] != 2'b11) |=> (out_seg == $past(ovr_seg)));

  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_ea) && $stable(out_seg) && $stable(out_dst_sel)));

endmodule

bind modrm_ea_decoder modrm_ea_checker #(.AW(AW)) u_chk (.*);

// File: tb/modrm_ea_decoder_tb.sv
`timescale 1ns/100ps
module modrm_ea_decoder_tb_top;

  localparam int AW = 16;

  typedef struct {
    logic [3:0]    dst;
    logic [3:0]    src;
    logic          is_mem;
    logic          wide;
    logic [AW-1:0] ea;
    logic [1:0]    seg;
    logic [1:0]    len;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          dir_bit = 1'b0;
  logic          wide_bit = 1'b0;
  logic [7:0]    modrm = '0;
  logic [7:0]    disp_lo = '0;
  logic [7:0]    disp_hi = '0;
  logic [AW-1:0] bx_val = '0;
  logic [AW-1:0] bp_val = '0;
  logic [AW-1:0] si_val = '0;
  logic [AW-1:0] di_val = '0;
  logic          ovr_valid = 1'b0;
  logic [1:0]    ovr_seg = '0;
  logic          out_valid;
  logic          out_wide;
  logic          out_is_mem;
  logic [3:0]    out_dst_sel;
  logic [3:0]    out_src_sel;
  logic [AW-1:0] out_ea;
  logic [1:0]    out_seg;
  logic [1:0]    out_disp_len;

  int total = 0;
  int bad = 0;
  exp_t  expq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  modrm_ea_decoder #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dir_bit(dir_bit), .wide_bit(wide_bit),
    .modrm(modrm), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .out_wide(out_wide), .out_is_mem(out_is_mem),
    .out_dst_sel(out_dst_sel), .out_src_sel(out_src_sel), .out_ea(out_ea),
    .out_seg(out_seg), .out_disp_len(out_disp_len)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model written from the requirement list.
  function automatic exp_t model(input logic d, input logic w, input logic [7:0] m,
                                 input logic [7:0] lo, input logic [7:0] hi,
                                 input logic [15:0] bx, input logic [15:0] bp,
                                 input logic [15:0] si, input logic [15:0] di,
                                 input logic ov, input logic [1:0] os);
    exp_t e;
    logic [1:0] md = m[7:6];
    logic [2:0] rg = m[5:3];
    logic [2:0] rm = m[2:0];
    logic [15:0] dsp = '0;
    logic [15:0] a = '0;
    logic uses_bp = 1'b0;
    logic [3:0] rmsel;
    e.wide = w;
    e.is_mem = (md != 2'b11);
    rmsel = e.is_mem ? 4'b1000 : {1'b0, rm};
    e.dst = d ? {1'b0, rg} : rmsel;
    e.src = d ? rmsel : {1'b0, rg};
    if (!e.is_mem) begin
      e.ea = '0; e.seg = 2'd3; e.len = 2'd0;
    end else if (md == 2'b00 && rm == 3'b110) begin
      e.ea = {hi, lo}; e.len = 2'd2; e.seg = ov ? os : 2'd3;
    end else begin
      if (md == 2'b01) begin dsp = {{8{lo[7]}}, lo}; e.len = 2'd1; end
      else if (md == 2'b10) begin dsp = {hi, lo}; e.len = 2'd2; end
      else e.len = 2'd0;
      case (rm)
        3'd0: a = bx + si;
        3'd1: a = bx + di;
        3'd2: begin a = bp + si; uses_bp = 1'b1; end
        3'd3: begin a = bp + di; uses_bp = 1'b1; end
        3'd4: a = si;
        3'd5: a = di;
        3'd6: begin a = bp; uses_bp = 1'b1; end
        default: a = bx;
      endcase
      e.ea = a + dsp;
      e.seg = ov ? os : (uses_bp ? 2'd2 : 2'd3);
    end
    return e;
  endfunction

  task automatic drive(input string tag, input logic d, input logic w, input logic [7:0] m,
                       input logic [7:0] lo, input logic [7:0] hi,
                       input logic [15:0] bx, input logic [15:0] bp,
                       input logic [15:0] si, input logic [15:0] di,
                       input logic ov, input logic [1:0] os);
    @(negedge clk);
    in_valid = 1'b1; dir_bit = d; wide_bit = w; modrm = m; disp_lo = lo; disp_hi = hi;
    bx_val = bx; bp_val = bp; si_val = si; di_val = di; ovr_valid = ov; ovr_seg = os;
    expq.push_back(model(d, w, m, lo, hi, bx, bp, si, di, ov, os));
    tagq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares each result against the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R12 unexpected result", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(out_ea == e.ea, {t, " offset"}, 32'(out_ea), 32'(e.ea));
        chk(out_seg == e.seg, {t, " segment R10/R11"}, 32'(out_seg), 32'(e.seg));
        chk(out_disp_len == e.len, {t, " length R5"}, 32'(out_disp_len), 32'(e.len));
        chk(out_dst_sel == e.dst && out_src_sel == e.src, {t, " selectors R3"},
            {24'd0, out_dst_sel, out_src_sel}, {24'd0, e.dst, e.src});
        chk(out_is_mem == e.is_mem, {t, " mem flag R2"}, 32'(out_is_mem), 32'(e.is_mem));
        chk(out_wide == e.wide, {t, " width R4"}, 32'(out_wide), 32'(e.wide));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] held_ea;
    logic [3:0]    held_dst;
    logic [1:0]    held_seg;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 32'd0);
    chk(out_ea == '0, "R1 offset after reset", 32'(out_ea), 32'd0);
    chk(out_disp_len == 2'd0, "R1 length after reset", 32'(out_disp_len), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4: register form, D=1 W=1 (reg=101, rm=100)
    drive("R2 reg form d1", 1'b1, 1'b1, 8'hEC, 8'h55, 8'h66, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 1'b0, 2'd0);
    // R3 R4: memory form [DI], D=0 W=0
    drive("R3 [DI] d0", 1'b0, 1'b0, 8'h15, 8'h00, 8'h00, 16'h0010, 16'h0020, 16'h0030, 16'h0400, 1'b0, 2'd0);
    // R5 R6: [DI+1]
    drive("R6 [DI+1]", 1'b1, 1'b0, 8'h55, 8'h01, 8'hAA, 16'h0010, 16'h0020, 16'h0030, 16'h0400, 1'b0, 2'd0);
    // R5: [DI+1000h]
    drive("R5 [DI+1000]", 1'b1, 1'b0, 8'h95, 8'h00, 8'h10, 16'h0010, 16'h0020, 16'h0030, 16'h0400, 1'b0, 2'd0);
    // R8: direct address with BP nonzero
    drive("R8 direct", 1'b0, 1'b0, 8'h16, 8'h00, 8'h10, 16'h0123, 16'h7777, 16'h0456, 16'h0789, 1'b0, 2'd0);
    // R10: bare BP through mode 01, zero displacement
    drive("R10 [BP+0]", 1'b0, 1'b1, 8'h56, 8'h00, 8'h99, 16'h0123, 16'h2468, 16'h0456, 16'h0789, 1'b0, 2'd0);
    // R6 R9: negative byte displacement wraps
    drive("R6 R9 [BX-80]", 1'b1, 1'b1, 8'h47, 8'h80, 8'h00, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 1'b0, 2'd0);
    // R9: BX+DI carry dropped
    drive("R9 [BX+DI] wrap", 1'b1, 1'b1, 8'h01, 8'h00, 8'h00, 16'h1000, 16'h0000, 16'h0000, 16'hFF00, 1'b0, 2'd0);
    // R10 R11: BP+SI default SS, then overridden to ES
    drive("R10 [BP+SI]", 1'b1, 1'b1, 8'h02, 8'h00, 8'h00, 16'h0000, 16'h3000, 16'h0042, 16'h0000, 1'b0, 2'd0);
    drive("R11 [BP+SI] ovr ES", 1'b1, 1'b1, 8'h02, 8'h00, 8'h00, 16'h0000, 16'h3000, 16'h0042, 16'h0000, 1'b1, 2'd0);
    // R11: override ignored in register form
    drive("R11 reg form ovr ignored", 1'b0, 1'b1, 8'hC3, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 2'd1);
    // R7: sweep all r/m codes with 16-bit displacement, back to back
    for (int k = 0; k < 8; k++) begin
      drive("R7 rm sweep", k[0], k[1], {2'b10, 3'(7 - k), 3'(k)}, 8'h34, 8'h12,
            16'h0101, 16'h0A0A, 16'h2020, 16'hC0C0, k[2], 2'd1);
    end
    // R7 R6: mode 01 sweep with a negative byte
    for (int k = 0; k < 8; k++) begin
      drive("R7 rm sweep d8", 1'b1, 1'b0, {2'b01, 3'(k), 3'(k)}, 8'hF0, 8'h00,
            16'h0101, 16'h0A0A, 16'h2020, 16'hC0C0, 1'b0, 2'd0);
    end
    idle();
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R12 all results delivered", 32'(expq.size()), 32'd0);

    // R12: hold while idle, inputs wiggling
    held_ea = out_ea; held_dst = out_dst_sel; held_seg = out_seg;
    modrm = 8'h00; bx_val = 16'hDEAD; disp_lo = 8'h7F; ovr_valid = 1'b1; ovr_seg = 2'd1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12 no valid when idle", 32'(out_valid), 32'd0);
    chk(out_ea == held_ea, "R12 offset held", 32'(out_ea), 32'(held_ea));
    chk(out_dst_sel == held_dst && out_seg == held_seg, "R12 selector/segment held",
        {26'd0, out_dst_sel, out_seg}, {26'd0, held_dst, held_seg});

    // R1: reset again mid-run
    drive("R1 pre-reset", 1'b1, 1'b1, 8'h80, 8'h11, 8'h22, 16'h0001, 16'h0, 16'h0002, 16'h0, 1'b0, 2'd0);
    idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_ea == '0, "R1 second reset", {15'd0, out_valid, out_ea}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule